// File: doc/BRIEF.md
# USB Endpoint Flag and Configuration Register Bank

This block keeps the control, configuration, status, interrupt-enable and interrupt-flag registers of five USB device endpoints. The CPU sees one endpoint's registers at a time through a small register window; a selector register at offset 0 chooses which endpoint that window shows. Flags are set by host-side events (IN token, OUT data, SETUP packet) and by buffer overflow or underflow pulses. Software can only clear them, by writing 0 to a bit that is set.

The host side presents one event per cycle with its endpoint number and receives a combinational response: ACK, NAK or STALL. This response is decided from the register state held before the cycle's edge. Packet storage lives in a separate buffer block. This block only records the resulting flags, a per-endpoint pending vector and one level-sensitive communication interrupt request.

Register window (cpu_addr): 0 endpoint selector, 1 control (bit0 enable, bit5 stall request, other bits read 0), 2 configuration A (bits[1:0] type, 0 = control; bit7 direction, 1 = IN), 3 configuration B (bit1 allocate), 4 status (bit7 config-OK, bit6 overflow, bit5 underflow), 5 interrupt enable (bits 0..3 enable the flags of the same position, bit7 enables overflow/underflow), 6 flags (bit0 transmit-ready, bit1 stalled, bit2 received-OUT, bit3 received-setup, bit5 read/write-allowed, bit6 FIFO-control, bits 4 and 7 read 0). Offset 7 reads 0 and ignores writes.

Top module: `usbep_flagcfg`

## Requirements
- R1: Reset clears every register, the pending vector and the interrupt request. Writing 0..4 to offset 0 selects that endpoint for offsets 1..6 and reads back the selection; writing a value of 5 or more leaves the selection unchanged.
- R2: A CPU write to offset 6 clears each of bits 0,1,2,3,6 where the written bit is 0 and the stored bit is 1, keeps them where the written bit is 1, and never changes bit 5.
- R3: When a flag write clears a set received-setup bit (bit3), received-OUT (bit2) is cleared as well.
- R4: Every flag-setting event sets the endpoint's bit in ep_summary. After a flag write, that bit is cleared when the endpoint's flags with bit 5 masked off (mask 0xDF) are all zero.
- R5: com_irq is high while, on any endpoint, a flag in bits 0..3 is set together with its enable bit, or status bit 5 or 6 is set together with enable bit 7.
- R6: Writing offset 2 clears config-OK (status bit7); writing offset 3 copies its bit1 into config-OK.
- R7: Writing offset 3 sets transmit-ready when the stored type is control. Otherwise, when the stored direction is IN, it sets transmit-ready, read/write-allowed and FIFO-control. Otherwise it clears received-OUT.
- R8: An IN or OUT event (host_ev_kind 0 or 1) on an endpoint whose stall request (control bit5) is set answers STALL (host_resp 2). It sets the stalled flag (bit1) of endpoint 0 and summary bit 0, and changes nothing else.
- R9: A SETUP event (host_ev_kind 2) answers ACK (0), clears the stall request and received-OUT, and sets received-setup.
- R10: An IN event answers NAK (1) when transmit-ready is set, or when FIFO-control is set on a non-control endpoint. An OUT event answers NAK under the same rules with received-OUT in place of transmit-ready. Kind 3 and endpoint numbers 5..7 answer NAK and have no effect. host_resp is 3 when no event is presented.
- R11: An IN event answered ACK sets FIFO-control and transmit-ready. An OUT event answered ACK sets FIFO-control and received-OUT.
- R12: A CPU write to offset 4 can only clear status bits 5 and 6 (written 0 while set); config-OK is kept.
- R13: buf_overflow / buf_underflow set status bit6 / bit5 of the selected endpoint and its summary bit.
- R14: In a cycle holding both a CPU write and a host event, the CPU write is applied first and the event's settings on top, so an event-set bit survives a same-cycle clear. The response reflects the state before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 3 | Register window offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| host_ev_valid | input | 1 | Host event present this cycle |
| host_ev_kind | input | 2 | 0 IN, 1 OUT, 2 SETUP, 3 none |
| host_ev_ep | input | 3 | Endpoint targeted by the host event |
| host_resp | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 idle |
| buf_overflow | input | 1 | Overflow pulse for the selected endpoint |
| buf_underflow | input | 1 | Underflow pulse for the selected endpoint |
| ep_summary | output | 5 | Per-endpoint pending bits |
| com_irq | output | 1 | Communication interrupt request (level) |

## Verification
The collision that matters is a CPU flag or configuration write landing in the same cycle as a host event on the same endpoint. One example is a write of zeros to the flag register alongside a SETUP packet. Another is a configuration write that clears received-OUT while an OUT packet is being answered. Directed cases force both pairs, and a long pseudo-random run mixes writes, events, out-of-range endpoints and buffer pulses freely. After every cycle the bench compares the response, all registers of the selected endpoint, the pending vector and the interrupt line against a bench model that applies the CPU write first and the event on top.

// File: rtl/usbep_pkg.sv
package usbep_pkg;

    localparam logic [2:0] ADR_SEL  = 3'd0;
    localparam logic [2:0] ADR_CTRL = 3'd1;
    localparam logic [2:0] ADR_CFGA = 3'd2;
    localparam logic [2:0] ADR_CFGB = 3'd3;
    localparam logic [2:0] ADR_STAT = 3'd4;
    localparam logic [2:0] ADR_IEN  = 3'd5;
    localparam logic [2:0] ADR_FLAG = 3'd6;

    // flag register bit positions
    localparam int FB_TXRDY   = 0;
    localparam int FB_STALLED = 1;
    localparam int FB_RXOUT   = 2;
    localparam int FB_SETUP   = 3;
    localparam int FB_RWAL    = 5;
    localparam int FB_FIFOCTL = 6;
    localparam logic [7:0] FLAG_KEEP_MASK = 8'h20;
    localparam logic [7:0] FLAG_PEND_MASK = 8'hDF;

    // status register bit positions
    localparam int SB_UNDER = 5;
    localparam int SB_OVER  = 6;
    localparam int SB_CFGOK = 7;
    localparam logic [7:0] STAT_CLR_MASK = 8'h60;

    // control / configuration bits
    localparam int CB_STALLRQ = 5;
    localparam logic [7:0] CTRL_MASK = 8'h21;
    localparam int CA_DIR_IN  = 7;
    localparam int CB_ALLOC   = 1;
    localparam int IE_FLOW    = 7;

    typedef enum logic [1:0] {
        EV_IN    = 2'd0,
        EV_OUT   = 2'd1,
        EV_SETUP = 2'd2,
        EV_NONE  = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        RSP_ACK   = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_IDLE  = 2'd3
    } rsp_e;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] cfga;
        logic [7:0] cfgb;
        logic [7:0] stat;
        logic [7:0] ien;
        logic [7:0] flag;
        logic       sum;
    } ep_regs_t;

    function automatic rsp_e ep_decide(ep_regs_t r, ev_kind_e k);
        logic busy;
        rsp_e res;
        busy = r.flag[FB_FIFOCTL] && (r.cfga[1:0] != 2'd0);
        case (k)
            EV_IN: begin
                if (r.ctrl[CB_STALLRQ])                 res = RSP_STALL;
                else if (r.flag[FB_TXRDY] || busy)      res = RSP_NAK;
                else                                    res = RSP_ACK;
            end
            EV_OUT: begin
                if (r.ctrl[CB_STALLRQ])                 res = RSP_STALL;
                else if (r.flag[FB_RXOUT] || busy)      res = RSP_NAK;
                else                                    res = RSP_ACK;
            end
            EV_SETUP: res = RSP_ACK;
            default:  res = RSP_NAK;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/usbep_slot.sv
module usbep_slot
    import usbep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       ev_hit,
    input  ev_kind_e   ev_kind,
    input  logic       stall_note,
    input  logic       ovf_hit,
    input  logic       udf_hit,
    output ep_regs_t   regs_o,
    output logic       irq_o
);

    ep_regs_t r_d, r_q;
    rsp_e     own_rsp;
    logic [7:0] flag_wr;

    always_comb begin
        r_d     = r_q;
        own_rsp = ep_decide(r_q, ev_kind);
        flag_wr = r_q.flag & (wr_data | FLAG_KEEP_MASK);
        if (r_q.flag[FB_SETUP] && !wr_data[FB_SETUP]) begin
            flag_wr[FB_RXOUT] = 1'b0;
        end

        // CPU side first
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: r_d.ctrl = wr_data & CTRL_MASK;
                ADR_CFGA: begin
                    r_d.cfga            = wr_data;
                    r_d.stat[SB_CFGOK]  = 1'b0;
                end
                ADR_CFGB: begin
                    r_d.cfgb            = wr_data;
                    r_d.stat[SB_CFGOK]  = wr_data[CB_ALLOC];
                    if (r_q.cfga[1:0] == 2'd0) begin
                        r_d.flag[FB_TXRDY] = 1'b1;
                    end else if (r_q.cfga[CA_DIR_IN]) begin
                        r_d.flag[FB_TXRDY]   = 1'b1;
                        r_d.flag[FB_RWAL]    = 1'b1;
                        r_d.flag[FB_FIFOCTL] = 1'b1;
                    end else begin
                        r_d.flag[FB_RXOUT] = 1'b0;
                    end
                end
                ADR_STAT: r_d.stat = (r_q.stat & ~STAT_CLR_MASK)
                                   | (wr_data & r_q.stat & STAT_CLR_MASK);
                ADR_IEN:  r_d.ien = wr_data;
                ADR_FLAG: begin
                    r_d.flag = flag_wr;
                    if ((flag_wr & FLAG_PEND_MASK) == 8'h00) begin
                        r_d.sum = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        // host side on top
        if (ev_hit) begin
            case (ev_kind)
                EV_IN: if (own_rsp == RSP_ACK) begin
                    r_d.flag[FB_FIFOCTL] = 1'b1;
                    r_d.flag[FB_TXRDY]   = 1'b1;
                    r_d.sum              = 1'b1;
                end
                EV_OUT: if (own_rsp == RSP_ACK) begin
                    r_d.flag[FB_FIFOCTL] = 1'b1;
                    r_d.flag[FB_RXOUT]   = 1'b1;
                    r_d.sum              = 1'b1;
                end
                EV_SETUP: begin
                    r_d.ctrl[CB_STALLRQ] = 1'b0;
                    r_d.flag[FB_RXOUT]   = 1'b0;
                    r_d.flag[FB_SETUP]   = 1'b1;
                    r_d.sum              = 1'b1;
                end
                default: ;
            endcase
        end
        if (stall_note) begin
            r_d.flag[FB_STALLED] = 1'b1;
            r_d.sum              = 1'b1;
        end
        if (ovf_hit) begin
            r_d.stat[SB_OVER] = 1'b1;
            r_d.sum           = 1'b1;
        end
        if (udf_hit) begin
            r_d.stat[SB_UNDER] = 1'b1;
            r_d.sum            = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs_o = r_q;
    assign irq_o  = (|(r_q.flag[3:0] & r_q.ien[3:0]))
                  | (r_q.ien[IE_FLOW] & (r_q.stat[SB_OVER] | r_q.stat[SB_UNDER]));

    AST_CFGA_DROPS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == ADR_CFGA |=> !r_q.stat[SB_CFGOK]); // R6

    AST_FLAG_WRITE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == ADR_FLAG && !ev_hit && !stall_note
        |=> (r_q.flag & ~$past(r_q.flag)) == 8'h00); // R2

    AST_SETUP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit && ev_kind == EV_SETUP
        |=> r_q.flag[FB_SETUP] && !r_q.ctrl[CB_STALLRQ] && r_q.sum); // R9

    AST_SETUP_CLR_TAKES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == ADR_FLAG && r_q.flag[FB_SETUP] && !wr_data[FB_SETUP]
        && !(ev_hit && ev_kind == EV_OUT) |=> !r_q.flag[FB_RXOUT]); // R3

endmodule

// File: rtl/usbep_flagcfg.sv
module usbep_flagcfg
    import usbep_pkg::*;
#(
    parameter int NUM_EP = 5,
    parameter int SELW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [2:0]        cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              host_ev_valid,
    input  logic [1:0]        host_ev_kind,
    input  logic [SELW-1:0]   host_ev_ep,
    output logic [1:0]        host_resp,
    input  logic              buf_overflow,
    input  logic              buf_underflow,
    output logic [NUM_EP-1:0] ep_summary,
    output logic              com_irq
);

    typedef struct packed {
        logic [SELW-1:0] sel;
    } top_state_t;

    top_state_t top_d, top_q;
    ep_regs_t   regs_w [NUM_EP];
    logic [NUM_EP-1:0] irq_w;
    ev_kind_e   kind;
    rsp_e       tgt_rsp;
    ep_regs_t   sel_regs;
    logic       stall_any;

    assign kind = ev_kind_e'(host_ev_kind);

    always_comb begin
        top_d = top_q;
        if (cpu_we && cpu_addr == ADR_SEL && cpu_wdata < 8'(NUM_EP)) begin
            top_d.sel = cpu_wdata[SELW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    // response of the targeted endpoint, from pre-edge state
    always_comb begin
        tgt_rsp = host_ev_valid ? RSP_NAK : RSP_IDLE;
        for (int i = 0; i < NUM_EP; i++) begin
            if (host_ev_valid && host_ev_ep == SELW'(i)) begin
                tgt_rsp = ep_decide(regs_w[i], kind);
            end
        end
    end
    assign stall_any = (tgt_rsp == RSP_STALL);
    assign host_resp = tgt_rsp;

    generate
        for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
            logic here;
            assign here = (top_q.sel == SELW'(g));
            usbep_slot u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (cpu_we && here && cpu_addr != ADR_SEL),
                .wr_addr    (cpu_addr),
                .wr_data    (cpu_wdata),
                .ev_hit     (host_ev_valid && host_ev_ep == SELW'(g)),
                .ev_kind    (kind),
                .stall_note ((g == 0) ? stall_any : 1'b0),
                .ovf_hit    (buf_overflow && here),
                .udf_hit    (buf_underflow && here),
                .regs_o     (regs_w[g]),
                .irq_o      (irq_w[g])
            );
            assign ep_summary[g] = regs_w[g].sum;
        end
    endgenerate

    assign com_irq = |irq_w;

    always_comb begin
        sel_regs = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (top_q.sel == SELW'(i)) sel_regs = regs_w[i];
        end
        case (cpu_addr)
            ADR_SEL:  cpu_rdata = 8'(top_q.sel);
            ADR_CTRL: cpu_rdata = sel_regs.ctrl;
            ADR_CFGA: cpu_rdata = sel_regs.cfga;
            ADR_CFGB: cpu_rdata = sel_regs.cfgb;
            ADR_STAT: cpu_rdata = sel_regs.stat;
            ADR_IEN:  cpu_rdata = sel_regs.ien;
            ADR_FLAG: cpu_rdata = sel_regs.flag;
            default:  cpu_rdata = 8'h00;
        endcase
    end

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        top_q.sel < SELW'(NUM_EP)); // R1

    AST_STALL_MARKS_EP0: assert property (@(posedge clk) disable iff (!rst_n)
        stall_any |=> regs_w[0].flag[FB_STALLED] && ep_summary[0]); // R8

    AST_SETUP_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        host_ev_valid && kind == EV_SETUP && host_ev_ep == '0 |=> ep_summary[0]); // R4

endmodule

// File: tb/usbep_flagcfg_bench.sv
`timescale 1ns/1ps
module usbep_flagcfg_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       host_ev_valid = 1'b0;
    logic [1:0] host_ev_kind = 2'd3;
    logic [2:0] host_ev_ep = 3'd0;
    logic [1:0] host_resp;
    logic       buf_overflow = 1'b0;
    logic       buf_underflow = 1'b0;
    logic [4:0] ep_summary;
    logic       com_irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_ctrl [5];
    logic [7:0] m_cfga [5];
    logic [7:0] m_cfgb [5];
    logic [7:0] m_stat [5];
    logic [7:0] m_ien  [5];
    logic [7:0] m_flag [5];
    logic [4:0] m_sum;
    int         m_sel;

    always #5 clk = ~clk;

    usbep_flagcfg u_usbep_flagcfg (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .host_ev_valid(host_ev_valid), .host_ev_kind(host_ev_kind),
        .host_ev_ep(host_ev_ep), .host_resp(host_resp),
        .buf_overflow(buf_overflow), .buf_underflow(buf_underflow),
        .ep_summary(ep_summary), .com_irq(com_irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_resp(int e, int k);
        logic busy;
        if (e >= 5 || k == 3) return 1;
        if (k == 2) return 0;
        if (m_ctrl[e][5]) return 2;
        busy = m_flag[e][6] && (m_cfga[e][1:0] != 2'd0);
        if (k == 0) return (m_flag[e][0] || busy) ? 1 : 0;
        return (m_flag[e][2] || busy) ? 1 : 0;
    endfunction

    function automatic logic exp_irq();
        logic v = 1'b0;
        for (int i = 0; i < 5; i++) begin
            v |= (|(m_flag[i][3:0] & m_ien[i][3:0])) | (m_ien[i][7] & (m_stat[i][5] | m_stat[i][6]));
        end
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin
            m_ctrl[i] = 0; m_cfga[i] = 0; m_cfgb[i] = 0;
            m_stat[i] = 0; m_ien[i] = 0; m_flag[i] = 0;
        end
        m_sum = 0; m_sel = 0;
    endtask

    // compare everything visible for the selected endpoint (R1..R13 by register)
    task automatic compare_all();
        chk(8'(ep_summary), 8'(m_sum), "R4 summary");
        chk(8'(com_irq), 8'(exp_irq()), "R5 irq");
        for (int a = 0; a < 7; a++) begin
            logic [7:0] ex;
            string tg;
            cpu_addr = 3'(a);
            #1;
            case (a)
                0: begin ex = 8'(m_sel);        tg = "R1 select"; end
                1: begin ex = m_ctrl[m_sel];    tg = "R9 control"; end
                2: begin ex = m_cfga[m_sel];    tg = "R6 cfgA"; end
                3: begin ex = m_cfgb[m_sel];    tg = "R7 cfgB"; end
                4: begin ex = m_stat[m_sel];    tg = "R12 status"; end
                5: begin ex = m_ien[m_sel];     tg = "R1 enable"; end
                default: begin ex = m_flag[m_sel]; tg = "R2 flags"; end
            endcase
            chk(cpu_rdata, ex, tg);
        end
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                        input logic hv, input logic [1:0] k, input logic [2:0] e,
                        input logic ov, input logic un);
        int er;
        int s;
        logic [7:0] nf;
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = d;
        host_ev_valid = hv; host_ev_kind = hv ? k : 2'd3; host_ev_ep = e;
        buf_overflow = ov; buf_underflow = un;
        #1;
        er = hv ? exp_resp(int'(e), int'(k)) : 3;
        chk(8'(host_resp), 8'(er), "R10 response");
        s = m_sel;
        if (we) begin
            case (a)
                3'd0: if (d < 5) m_sel = int'(d);
                3'd1: m_ctrl[s] = d & 8'h21;
                3'd2: begin m_cfga[s] = d; m_stat[s][7] = 1'b0; end
                3'd3: begin
                    m_cfgb[s] = d; m_stat[s][7] = d[1];
                    if (m_cfga[s][1:0] == 2'd0) m_flag[s][0] = 1'b1;
                    else if (m_cfga[s][7]) m_flag[s] = m_flag[s] | 8'h61;
                    else m_flag[s][2] = 1'b0;
                end
                3'd4: m_stat[s] = (m_stat[s] & 8'h9F) | (d & m_stat[s] & 8'h60);
                3'd5: m_ien[s] = d;
                3'd6: begin
                    nf = m_flag[s] & (d | 8'h20);
                    if (m_flag[s][3] && !d[3]) nf[2] = 1'b0;
                    m_flag[s] = nf;
                    if ((nf & 8'hDF) == 0) m_sum[s] = 1'b0;
                end
                default: ;
            endcase
        end
        if (hv && e < 5) begin
            case (k)
                2'd0: if (er == 0) begin m_flag[e] = m_flag[e] | 8'h41; m_sum[e] = 1'b1; end
                2'd1: if (er == 0) begin m_flag[e] = m_flag[e] | 8'h44; m_sum[e] = 1'b1; end
                2'd2: begin
                    m_ctrl[e][5] = 1'b0; m_flag[e][2] = 1'b0;
                    m_flag[e][3] = 1'b1; m_sum[e] = 1'b1;
                end
                default: ;
            endcase
            if (er == 2) begin m_flag[0][1] = 1'b1; m_sum[0] = 1'b1; end
        end
        if (ov) begin m_stat[s][6] = 1'b1; m_sum[s] = 1'b1; end
        if (un) begin m_stat[s][5] = 1'b1; m_sum[s] = 1'b1; end
        @(posedge clk);
        #1;
        cpu_we = 1'b0; host_ev_valid = 1'b0; host_ev_kind = 2'd3;
        buf_overflow = 1'b0; buf_underflow = 1'b0;
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 2'd3, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic ev(input logic [1:0] k, input logic [2:0] e);
        step(1'b0, 3'd0, 8'h00, 1'b1, k, e, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        cpu_addr = a; #1; v = cpu_rdata;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [31:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        compare_all();

        // R1 out-of-range selection ignored
        wr(3'd0, 8'd3);
        wr(3'd0, 8'd5);
        rd(3'd0, v); chk(v, 8'd3, "R1 sel ignore 5");
        wr(3'd0, 8'd0);

        // R7 exhaustive config side effects per endpoint, type and direction
        for (int ep = 0; ep < 5; ep++) begin
            wr(3'd0, 8'(ep));
            for (int c = 0; c < 16; c++) begin
                wr(3'd2, {c[2], 5'b0, c[1:0]});
                wr(3'd3, {6'b0, c[3], 1'b0});
                rd(3'd4, v); chk(v & 8'h80, {c[3], 7'b0}, "R6 cfg-ok");
                wr(3'd6, 8'h00);
            end
        end

        // R11 accepted IN on a control endpoint 1
        wr(3'd0, 8'd1);
        wr(3'd2, 8'h00);
        wr(3'd6, 8'h00);
        ev(2'd0, 3'd1);
        rd(3'd6, v); chk(v & 8'h41, 8'h41, "R11 IN sets");

        // R3: OUT, SETUP, OUT then clear setup only
        wr(3'd0, 8'd0);
        wr(3'd2, 8'h00);
        ev(2'd1, 3'd0);
        ev(2'd2, 3'd0);
        ev(2'd1, 3'd0);
        wr(3'd6, 8'hF7);
        rd(3'd6, v); chk(v & 8'h0C, 8'h00, "R3 setup clears out");

        // R8 stall on endpoint 2, marks endpoint 0
        wr(3'd6, 8'h00);
        wr(3'd0, 8'd2);
        wr(3'd1, 8'h21);
        ev(2'd1, 3'd2);
        chk(8'(ep_summary[0]), 8'h01, "R8 ep0 pending");
        ev(2'd2, 3'd2);
        rd(3'd1, v); chk(v, 8'h01, "R9 setup clears stall");

        // R13 overflow/underflow and R12 clear-only
        step(1'b0, 3'd0, 8'h00, 1'b0, 2'd3, 3'd0, 1'b1, 1'b1);
        rd(3'd4, v); chk(v & 8'h60, 8'h60, "R13 flow bits");
        wr(3'd4, 8'hFF);
        wr(3'd4, 8'h9F);
        rd(3'd4, v); chk(v & 8'h60, 8'h00, "R12 clear-only");

        // R14 same-cycle clear and setup: setup survives
        step(1'b1, 3'd6, 8'h00, 1'b1, 2'd2, 3'd2, 1'b0, 1'b0);
        rd(3'd6, v); chk(v & 8'h08, 8'h08, "R14 setup survives clear");
        // R14 OUT answered from pre-state while cfgB clears received-OUT
        wr(3'd2, 8'h02);
        wr(3'd6, 8'h00);
        ev(2'd1, 3'd2);
        wr(3'd6, 8'hBF);
        step(1'b1, 3'd3, 8'h02, 1'b1, 2'd1, 3'd2, 1'b0, 1'b0);
        rd(3'd6, v); chk(v & 8'h04, 8'h00, "R14 cfg clears out");

        // pseudo-random sweep
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r0;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r0 = lfsr * 32'h9E37_79B9;
            step(r0[0], r0[3:1], r0[11:4], r0[14:12] < 3'd3, r0[16:15],
                 {1'b0, r0[18:17]} + {2'b0, r0[19] & r0[20]} * 3'd5,
                 r0[25:21] == 5'd0, r0[30:26] == 5'd1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule